// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block sits between the two independent access ports of a shared memory array and settles collisions. A collision exists when both ports are enabled and present the same address. On every clock it compares the two requests, picks one port as the owner of the contested word, and raises a busy flag toward the other port. The owner is chosen by history. A port whose enable and address were already in place on the previous cycle has priority over a port that has only just arrived. This one rule covers both the enable-first case and the address-first case. When both ports arrive in the same cycle, the left port wins.

A strap input selects the direction of busy. With the strap high (master), the internal arbiter drives the busy outputs. With the strap low (slave), each busy output repeats an externally supplied busy input, so several devices can follow one master when the data path is widened. In both modes the effective busy gates the write strobe that the block hands to the array. Reads always reach the array, and a read-valid flag marks whether the returned word can be trusted.

Top module: `dp_collide_arb`

## Requirements
- R1: After reset, with no port enabled and the strap high, both busy outputs and both write strobes are 0.
- R2: With equal addresses, the port whose enable was already active on the previous cycle wins. The port enabled later sees its busy output go to 1 in the same cycle as the collision.
- R3: With both enables active, the port whose address was already equal to the contested address on the previous cycle wins. The port that has just moved its address onto it is busied.
- R4: If both ports start requesting the same address in the same cycle, the left port wins and the right busy output is 1.
- R5: Busy to the losing port stays at 1 for as long as the collision lasts. It also stays at 1 during the first cycle after the collision ends, and reads 0 on the cycle after that.
- R6: With the strap high (1 = master), the external busy inputs have no effect on any output.
- R7: With the strap low (0 = slave), each busy output equals that port's external busy input, and the internal arbitration does not affect it.
- R8: A port's write strobe is 1 exactly when its enable is 1, its write select is 1 (1 = write, 0 = read), and its effective busy is 0.
- R9: A port's read strobe is 1 whenever it is enabled with write select 0, whatever its busy. Its read-valid flag is the read strobe with busy clear.
- R10: With the strap high and a collision present, at least one of the two busy outputs is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_sel | input | 1 | Strap: 1 = master (internal busy), 0 = slave (external busy) |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left write select, 1 = write |
| l_addr | input | AW | Left port address |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right write select, 1 = write |
| r_addr | input | AW | Right port address |
| l_busy_i | input | 1 | External busy toward the left port (slave mode) |
| r_busy_i | input | 1 | External busy toward the right port (slave mode) |
| l_busy_o | output | 1 | Effective busy of the left port |
| r_busy_o | output | 1 | Effective busy of the right port |
| l_wr_o | output | 1 | Left write strobe to the array |
| r_wr_o | output | 1 | Right write strobe to the array |
| l_rd_o | output | 1 | Left read strobe to the array |
| r_rd_o | output | 1 | Right read strobe to the array |
| l_rvld_o | output | 1 | Left read data valid |
| r_rvld_o | output | 1 | Right read data valid |

## Verification
The delicate case is a port's write landing in the same cycle that the arbiter busies that port. The strobe is gated combinationally by that very decision, so the dropped write and the busy flag must agree within one cycle. The bench provokes this by moving one port onto an address the other already holds, by starting both ports together, and by sweeping pseudo-random enable, write, address and strap patterns over a two-bit address space, where about a quarter of enabled pairs collide. A cycle-level model in the bench computes expected busy, strobe and valid outputs each cycle from the arrival history, and the bench also checks that a collision in master mode never leaves both ports unbusied.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_e;

   localparam int unsigned NPORT = 2;
   localparam int unsigned P_LEFT  = 0;
   localparam int unsigned P_RIGHT = 1;

   typedef struct packed {
      logic ce;
      logic we;
   } req_t;

endpackage

// File: rtl/dpa_track.sv
module dpa_track #(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce,
   input  logic [AW-1:0] addr,
   output logic          steady
);

   logic          ce_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         ce_q   <= ce;
         addr_q <= addr;
      end
   end

   // request unchanged since the previous cycle
   assign steady = ce & ce_q & (addr_q == addr);

endmodule

// File: rtl/dpa_decide.sv
module dpa_decide
   import dpa_pkg::*;
#(
   parameter int unsigned AW   = 4,
   parameter bit          HOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] ce,
   input  logic [AW-1:0]    addr_l,
   input  logic [AW-1:0]    addr_r,
   input  logic [NPORT-1:0] steady,
   output logic             match,
   output logic [NPORT-1:0] busy
);

   own_e             owner_q;
   own_e             owner_d;
   own_e             fresh;
   own_e             win;
   logic [NPORT-1:0] lose_now;

   assign match = ce[P_LEFT] & ce[P_RIGHT] & (addr_l == addr_r);

   // the earlier arrival wins; a tie goes to the left port
   always_comb begin
      if (steady[P_RIGHT] && !steady[P_LEFT]) fresh = OWN_RIGHT;
      else                                    fresh = OWN_LEFT;
   end

   always_comb begin
      win = (owner_q != OWN_NONE) ? owner_q : fresh;
      lose_now[P_LEFT]  = match & (win == OWN_RIGHT);
      lose_now[P_RIGHT] = match & (win == OWN_LEFT);
      owner_d = match ? win : OWN_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner_d;
   end

   generate
      if (HOLD) begin : g_hold
         logic [NPORT-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= '0;
            else        hold_q <= lose_now;
         end
         assign busy = lose_now | hold_q;
      end else begin : g_nohold
         assign busy = lose_now;
      end
   endgenerate

endmodule

// File: rtl/dpa_gate.sv
module dpa_gate
   import dpa_pkg::*;
(
   input  logic mst,
   input  req_t req,
   input  logic busy_int,
   input  logic busy_ext,
   output logic busy_o,
   output logic wr_o,
   output logic rd_o,
   output logic rvld_o
);

   always_comb begin
      busy_o = mst ? busy_int : busy_ext;
      wr_o   = req.ce & req.we & ~busy_o;
      rd_o   = req.ce & ~req.we;
      rvld_o = rd_o & ~busy_o;
   end

endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
   import dpa_pkg::*;
#(
   parameter int unsigned AW   = 4,
   parameter bit          HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mst_sel,
   input  logic          l_ce,
   input  logic          l_we,
   input  logic [AW-1:0] l_addr,
   input  logic          r_ce,
   input  logic          r_we,
   input  logic [AW-1:0] r_addr,
   input  logic          l_busy_i,
   input  logic          r_busy_i,
   output logic          l_busy_o,
   output logic          r_busy_o,
   output logic          l_wr_o,
   output logic          r_wr_o,
   output logic          l_rd_o,
   output logic          r_rd_o,
   output logic          l_rvld_o,
   output logic          r_rvld_o
);

   generate
      if (AW < 1 || AW > 32) begin : g_bad_aw
         $error("dp_collide_arb: AW must lie in 1..32");
      end
   endgenerate

   req_t             req    [NPORT];
   logic [AW-1:0]    addr   [NPORT];
   logic [NPORT-1:0] ce_v;
   logic [NPORT-1:0] steady;
   logic [NPORT-1:0] busy_int;
   logic [NPORT-1:0] busy_ext;
   logic [NPORT-1:0] busy_v;
   logic [NPORT-1:0] wr_v;
   logic [NPORT-1:0] rd_v;
   logic [NPORT-1:0] rvld_v;
   logic             match;

   assign req[P_LEFT]       = '{ce: l_ce, we: l_we};
   assign req[P_RIGHT]      = '{ce: r_ce, we: r_we};
   assign addr[P_LEFT]      = l_addr;
   assign addr[P_RIGHT]     = r_addr;
   assign busy_ext[P_LEFT]  = l_busy_i;
   assign busy_ext[P_RIGHT] = r_busy_i;

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         assign ce_v[p] = req[p].ce;

         dpa_track #(.AW(AW)) u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .ce     (req[p].ce),
            .addr   (addr[p]),
            .steady (steady[p])
         );

         dpa_gate u_gate (
            .mst      (mst_sel),
            .req      (req[p]),
            .busy_int (busy_int[p]),
            .busy_ext (busy_ext[p]),
            .busy_o   (busy_v[p]),
            .wr_o     (wr_v[p]),
            .rd_o     (rd_v[p]),
            .rvld_o   (rvld_v[p])
         );
      end
   endgenerate

   dpa_decide #(.AW(AW), .HOLD(HOLD)) u_decide (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (ce_v),
      .addr_l (l_addr),
      .addr_r (r_addr),
      .steady (steady),
      .match  (match),
      .busy   (busy_int)
   );

   assign l_busy_o = busy_v[P_LEFT];
   assign r_busy_o = busy_v[P_RIGHT];
   assign l_wr_o   = wr_v[P_LEFT];
   assign r_wr_o   = wr_v[P_RIGHT];
   assign l_rd_o   = rd_v[P_LEFT];
   assign r_rd_o   = rd_v[P_RIGHT];
   assign l_rvld_o = rvld_v[P_LEFT];
   assign r_rvld_o = rvld_v[P_RIGHT];

endmodule

// File: rtl/dp_collide_arb_chk.sv
module dp_collide_arb_chk #(
   parameter int unsigned AW   = 4,
   parameter bit          HOLD = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mst_sel,
   input logic          l_ce,
   input logic          l_we,
   input logic [AW-1:0] l_addr,
   input logic          r_ce,
   input logic          r_we,
   input logic [AW-1:0] r_addr,
   input logic          l_busy_i,
   input logic          r_busy_i,
   input logic          l_busy_o,
   input logic          r_busy_o,
   input logic          l_wr_o,
   input logic          r_wr_o,
   input logic          l_rd_o,
   input logic          r_rd_o,
   input logic          l_rvld_o,
   input logic          r_rvld_o
);

   logic clash;
   assign clash = l_ce && r_ce && (l_addr == r_addr);

   AST_NO_DOUBLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_sel && clash) |-> (l_busy_o || r_busy_o)); // R10

   AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !mst_sel |-> (l_busy_o == l_busy_i && r_busy_o == r_busy_i)); // R7

   AST_LEFT_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      l_busy_o |-> !l_wr_o); // R8

   AST_RIGHT_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      r_busy_o |-> !r_wr_o); // R8

   AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ((l_ce && !l_we) |-> l_rd_o) and ((r_ce && !r_we) |-> r_rd_o)); // R9

   AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_sel && clash && !$past(l_ce) && !$past(r_ce)) |-> (r_busy_o && !l_busy_o)); // R4

   generate
      if (HOLD) begin : g_hold_chk
         AST_RELEASE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            (mst_sel && $past(mst_sel) && ($fell(l_busy_o) || $fell(r_busy_o))) |-> $past(!clash)); // R5
      end
   endgenerate

endmodule

bind dp_collide_arb dp_collide_arb_chk #(.AW(AW), .HOLD(HOLD)) u_chk (
   .clk(clk), .rst_n(rst_n), .mst_sel(mst_sel),
   .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
   .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
   .l_busy_i(l_busy_i), .r_busy_i(r_busy_i),
   .l_busy_o(l_busy_o), .r_busy_o(r_busy_o),
   .l_wr_o(l_wr_o), .r_wr_o(r_wr_o),
   .l_rd_o(l_rd_o), .r_rd_o(r_rd_o),
   .l_rvld_o(l_rvld_o), .r_rvld_o(r_rvld_o)
);

// File: tb/dp_collide_arb_test.sv
`timescale 1ns/100ps
module dp_collide_arb_test;

   localparam int unsigned AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mst_sel = 1'b1;
   logic          l_ce = 1'b0, l_we = 1'b0, r_ce = 1'b0, r_we = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_busy_i = 1'b0, r_busy_i = 1'b0;
   logic          l_busy_o, r_busy_o, l_wr_o, r_wr_o;
   logic          l_rd_o, r_rd_o, l_rvld_o, r_rvld_o;

   int n_chk  = 0;
   int n_fail = 0;

   // reference state
   int            m_owner = 0;     // 0 none, 1 left, 2 right
   bit            m_pce_l = 0, m_pce_r = 0;
   logic [AW-1:0] m_pa_l = '0, m_pa_r = '0;
   bit            m_hold_l = 0, m_hold_r = 0;

   always #2.5 clk = ~clk;

   dp_collide_arb #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .mst_sel(mst_sel),
      .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
      .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
      .l_busy_i(l_busy_i), .r_busy_i(r_busy_i),
      .l_busy_o(l_busy_o), .r_busy_o(r_busy_o),
      .l_wr_o(l_wr_o), .r_wr_o(r_wr_o),
      .l_rd_o(l_rd_o), .r_rd_o(r_rd_o),
      .l_rvld_o(l_rvld_o), .r_rvld_o(r_rvld_o)
   );

   task automatic check(input logic act, input logic exp, input string tag, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // drive one cycle of stimulus, compare every output with the model, advance the model
   task automatic step(input bit lce, input bit lwe, input int la,
                       input bit rce, input bit rwe, input int ra,
                       input bit mst, input bit bli, input bit bri);
      bit match, lold, rold, bl_now, br_now, bl, br;
      int win;
      @(negedge clk);
      l_ce = lce; l_we = lwe; l_addr = AW'(la);
      r_ce = rce; r_we = rwe; r_addr = AW'(ra);
      mst_sel = mst; l_busy_i = bli; r_busy_i = bri;
      #1;
      match = lce && rce && (AW'(la) == AW'(ra));
      lold  = lce && m_pce_l && (m_pa_l == AW'(la));
      rold  = rce && m_pce_r && (m_pa_r == AW'(ra));
      if (m_owner != 0) win = m_owner;
      else win = (rold && !lold) ? 2 : 1;
      bl_now = match && (win == 2);
      br_now = match && (win == 1);
      bl = mst ? (bl_now || m_hold_l) : bli;
      br = mst ? (br_now || m_hold_r) : bri;
      check(l_busy_o, bl, mst ? "R5" : "R7", "left busy");
      check(r_busy_o, br, mst ? "R5" : "R7", "right busy");
      check(l_wr_o, lce && lwe && !bl, "R8", "left write");
      check(r_wr_o, rce && rwe && !br, "R8", "right write");
      check(l_rd_o, lce && !lwe, "R9", "left read");
      check(r_rd_o, rce && !rwe, "R9", "right read");
      check(l_rvld_o, lce && !lwe && !bl, "R9", "left valid");
      check(r_rvld_o, rce && !rwe && !br, "R9", "right valid");
      if (mst && match) check(l_busy_o || r_busy_o, 1'b1, "R10", "collision unguarded");
      m_owner  = match ? win : 0;
      m_hold_l = bl_now; m_hold_r = br_now;
      m_pce_l  = lce;    m_pce_r  = rce;
      m_pa_l   = AW'(la); m_pa_r  = AW'(ra);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0, 0);
   endtask

   initial begin
      #1000000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset
      step(0, 1, 0, 0, 1, 0, 1, 0, 0);
      check(l_busy_o, 1'b0, "R1", "left busy after reset");
      check(r_busy_o, 1'b0, "R1", "right busy after reset");

      // R2: right enabled first on address 1, left joins later
      step(0, 0, 1, 1, 0, 1, 1, 0, 0);
      step(1, 1, 1, 1, 0, 1, 1, 0, 0);
      check(l_busy_o, 1'b1, "R2", "late left busied");
      check(r_busy_o, 1'b0, "R2", "early right free");
      check(l_wr_o,   1'b0, "R8", "busied left write dropped");
      // R5: persists while clash lasts
      step(1, 1, 1, 1, 0, 1, 1, 0, 0);
      step(1, 1, 1, 1, 0, 1, 1, 0, 0);
      check(l_busy_o, 1'b1, "R5", "busy during clash");
      // right releases: one trailing cycle, then clear
      step(1, 1, 1, 0, 0, 1, 1, 0, 0);
      check(l_busy_o, 1'b1, "R5", "trailing busy");
      step(1, 1, 1, 0, 0, 1, 1, 0, 0);
      check(l_busy_o, 1'b0, "R5", "busy cleared");
      check(l_wr_o,   1'b1, "R8", "write after clear");
      idle();

      // R3: left settled on 0, right moves onto 0
      step(1, 0, 0, 1, 1, 2, 1, 0, 0);
      step(1, 0, 0, 1, 1, 0, 1, 0, 0);
      check(r_busy_o, 1'b1, "R3", "mover right busied");
      check(l_busy_o, 1'b0, "R3", "settled left free");
      check(r_wr_o,   1'b0, "R8", "right write dropped");
      check(l_rd_o,   1'b1, "R9", "left read passes");
      idle();
      // R3 mirrored: right settled on 3, left moves onto 3 with a read
      step(1, 0, 1, 1, 1, 3, 1, 0, 0);
      step(1, 0, 3, 1, 1, 3, 1, 0, 0);
      check(l_busy_o, 1'b1, "R3", "mover left busied");
      check(l_rd_o,   1'b1, "R9", "busied read still issued");
      check(l_rvld_o, 1'b0, "R9", "busied read invalid");
      check(r_wr_o,   1'b1, "R8", "owner right writes");
      idle();

      // R4: simultaneous arrival, left wins
      step(1, 1, 2, 1, 1, 2, 1, 0, 0);
      check(r_busy_o, 1'b1, "R4", "right loses tie");
      check(l_busy_o, 1'b0, "R4", "left wins tie");
      idle();

      // R6: external busy ignored in master mode
      step(1, 1, 1, 1, 1, 2, 1, 1, 1);
      check(l_busy_o, 1'b0, "R6", "left ext ignored");
      check(r_wr_o,   1'b1, "R6", "right write despite ext");
      idle();

      // R7: slave mode follows external busy, even during a clash
      step(1, 1, 2, 1, 1, 2, 0, 1, 0);
      check(l_busy_o, 1'b1, "R7", "left follows ext");
      check(l_wr_o,   1'b0, "R7", "left write gated by ext");
      check(r_busy_o, 1'b0, "R7", "right follows ext");
      check(r_wr_o,   1'b1, "R7", "right writes in slave");
      idle();

      // sweep over the small address space
      begin
         logic [15:0] lf = 16'hACE1;
         for (int i = 0; i < 6000; i++) begin
            for (int k = 0; k < 11; k++)
               lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], lf[2], int'(lf[4:3]),
                 lf[5] | lf[6], lf[7], int'(lf[9:8]),
                 (i % 500) < 420, lf[10], lf[11]);
         end
      end

      summary();
   end

endmodule